// File: doc/BRIEF.md
# Multi-function configuration target decoder

This block answers configuration-space accesses for a bus device that holds up to eight functions. Each request arrives as a single-cycle strobe. It carries:

- a device select;
- a two-bit access type;
- a function number;
- a dword offset into the 16-byte common header;
- byte enables, a read/write flag and write data.

The block decides whether to claim the request. If it does, it acknowledges one cycle later and returns read data in that same cycle. If it does not, it stays silent, and a bus-level wrapper ends the access with a no-response status.

The device is single-function or multi-function, set by an implemented-function mask parameter. Function 0 is always present. When no other function is present, the device is single-function: it ignores the function number and always serves function 0. Otherwise it decodes the function number fully and claims only functions that are present.

Every function has the same four-dword header:

| Dword | Contents | Access |
|-------|----------|--------|
| 0 | Identity (vendor and device) | read-only parameter |
| 1 | Command register | writable per function |
| 2 | Class and revision | read-only parameter |
| 3 | Header-type byte | read-only; carries the multi-function flag and a layout code |

Top module: `cfgTargetDecoder`

## Requirements
- R1: A request is claimed only when `reqSel` is 1 and `reqType` equals 2'b00. Any other request produces no acknowledge.
- R2: When `IMPL_MASK` has only bit 0 set, the decoder is in single-function mode. It claims every selected type-00 request whatever `reqFunc` holds, and serves the function 0 registers for it.
- R3: Otherwise, the decoder claims a selected type-00 request only if bit `reqFunc` of the effective mask (`IMPL_MASK` with bit 0 forced to 1) is set. Function 0 is therefore always claimed.
- R4: Whether a request is claimed never depends on `reqDword`. A present function answers at all four dword offsets.
- R5: Dword 3 reads as {8'h00, header-type byte, 16'h0000}. In the header-type byte, bit 7 is 1 exactly when any function other than 0 is present, and bits 6:0 equal `LAYOUT_CODE`. Bit 7 does not depend on the value of `LAYOUT_CODE`.
- R6: Dword 0 reads as {`DEVICE_BASE` + f, `VENDOR_ID`} and dword 2 reads as {`CLASS_CODE`, 8-bit f}, where f is the served function. Writes to dwords 0, 2 and 3 are acknowledged but change nothing.
- R7: Dword 1 bits 15:0 form a per-function command register that resets to 0. A write updates byte 0 when `reqByteEn[0]` is 1 and byte 1 when `reqByteEn[1]` is 1. Bits 31:16 always read 0. A write to one function leaves the other functions unchanged.
- R8: A claimed request raises `ackValid` for exactly one cycle, in the cycle after the request. Read data is valid in that cycle. There is no acknowledge without a request.
- R9: `rdData` is 32'hFFFF_FFFF whenever `ackValid` is 0, and also during the acknowledge of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqSel | input | 1 | Device select for this request |
| reqType | input | 2 | Access type; 2'b00 addresses this device |
| reqFunc | input | FUNC_BITS | Function number |
| reqDword | input | 2 | Dword offset in the 16-byte header |
| reqByteEn | input | 4 | Byte enables for writes |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 32 | Write data |
| ackValid | output | 1 | Acknowledge, one cycle after a claimed request |
| rdData | output | 32 | Read data; all ones unless acknowledging a read |

## Verification
The bench steps through all eight function numbers. It drives two instances from the same stimulus: one with a sparse mask and one in single-function mode. This catches a decoder that claims absent functions, drops function 0, or keeps decoding the function field in single-function mode (that last fault would leave most requests unanswered).

It sets the layout code to all ones on the multi-function instance. A design that folds the layout code into the multi-function flag, or derives the flag from the wrong mask bits, then returns the wrong header byte.

It writes with partial byte enables to different functions and to read-only dwords. This exposes a command register shared between functions, enables applied to the wrong bytes, and identity values that can be overwritten.

Every acknowledge is followed by a check that the next cycle is silent and that the data reads all ones. A stretched acknowledge, or stale data left on the bus, is therefore reported.

// File: rtl/cfgPkg.sv
package cfgPkg;

  // Strobes passed from the claim logic to the register datapath.
  typedef struct packed {
    logic ackNext;   // request claimed; acknowledge next cycle
    logic readNext;  // claimed read; capture read data
    logic cmdWrite;  // claimed write aimed at the command dword
  } cfgStrobe_t;

  localparam logic [1:0] DW_IDENT  = 2'd0;
  localparam logic [1:0] DW_CMD    = 2'd1;
  localparam logic [1:0] DW_CLASS  = 2'd2;
  localparam logic [1:0] DW_HEADER = 2'd3;

  // Only the two low bytes of the command dword accept writes.
  localparam logic [3:0] CMD_WR_BYTES = 4'b0011;

endpackage

// File: rtl/cfgControl.sv
module cfgControl
  import cfgPkg::*;
#(
  parameter int FUNC_BITS = 3,
  parameter logic [(1<<FUNC_BITS)-1:0] IMPL_MASK = 'h01
) (
  input  logic                 reqValid,
  input  logic                 reqSel,
  input  logic [1:0]           reqType,
  input  logic [FUNC_BITS-1:0] reqFunc,
  input  logic [1:0]           reqDword,
  input  logic                 reqWrite,
  output cfgStrobe_t           strobe,
  output logic [FUNC_BITS-1:0] funcIdx,
  output logic                 multiFlag
);

  localparam int NUM_FUNC = 1 << FUNC_BITS;

  // Function 0 is always present, whatever the mask parameter says.
  localparam logic [NUM_FUNC-1:0] EFF_MASK = IMPL_MASK | NUM_FUNC'(1);
  localparam logic IS_MULTI = |EFF_MASK[NUM_FUNC-1:1];

  logic typeOk;
  logic funcHit;
  logic claim;

  always_comb begin
    typeOk    = reqSel && (reqType == 2'b00);

    // Single-function mode ignores the function field entirely.
    funcHit   = IS_MULTI ? EFF_MASK[reqFunc] : 1'b1;
    claim     = reqValid && typeOk && funcHit;
    funcIdx   = IS_MULTI ? reqFunc : '0;
    multiFlag = IS_MULTI;

    strobe.ackNext  = claim;
    strobe.readNext = claim && !reqWrite;
    strobe.cmdWrite = claim && reqWrite && (reqDword == DW_CMD);
  end

endmodule

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgPkg::*;
#(
  parameter int FUNC_BITS = 3,
  parameter logic [(1<<FUNC_BITS)-1:0] IMPL_MASK = 'h01,
  parameter logic [15:0] VENDOR_ID = 16'h1D2C,
  parameter logic [15:0] DEVICE_BASE = 16'h4410,
  parameter logic [23:0] CLASS_CODE = 24'h0C0330,
  parameter logic [6:0] LAYOUT_CODE = 7'h00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic [FUNC_BITS-1:0] funcIdx,
  input  logic [1:0]           reqDword,
  input  logic [3:0]           reqByteEn,
  input  logic [31:0]          reqWdata,
  input  logic                 multiFlag,
  output logic                 ackValid,
  output logic [31:0]          rdData
);

  localparam int NUM_FUNC = 1 << FUNC_BITS;
  localparam logic [NUM_FUNC-1:0] EFF_MASK = IMPL_MASK | NUM_FUNC'(1);

  logic [NUM_FUNC-1:0][31:0] cmdWord;
  logic [NUM_FUNC-1:0][31:0] identWord;
  logic [NUM_FUNC-1:0][31:0] classWord;
  logic [31:0]               headerWord;
  logic [31:0]               readMux;

  for (genvar g = 0; g < NUM_FUNC; g++) begin : gFunc
    assign identWord[g] = {DEVICE_BASE + 16'(g), VENDOR_ID};
    assign classWord[g] = {CLASS_CODE, 8'(g)};

    if (EFF_MASK[g]) begin : gImpl
      logic [31:0] cmdReg;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cmdReg <= '0;
        end else if (strobe.cmdWrite && (funcIdx == FUNC_BITS'(g))) begin
          for (int b = 0; b < 4; b++) begin
            if (reqByteEn[b] && CMD_WR_BYTES[b]) begin
              cmdReg[8*b +: 8] <= reqWdata[8*b +: 8];
            end
          end
        end
      end
      assign cmdWord[g] = cmdReg;
    end else begin : gAbsent
      assign cmdWord[g] = '0;
    end
  end

  assign headerWord = {8'h00, multiFlag, LAYOUT_CODE, 16'h0000};

  always_comb begin
    unique case (reqDword)
      DW_IDENT: readMux = identWord[funcIdx];
      DW_CMD:   readMux = cmdWord[funcIdx];
      DW_CLASS: readMux = classWord[funcIdx];
      default:  readMux = headerWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      rdData   <= '1;
    end else begin
      ackValid <= strobe.ackNext;
      rdData   <= strobe.readNext ? readMux : '1;
    end
  end

  // R7: command state changes only on a claimed command write.
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cmdWrite |=> $stable(cmdWord));

  // R8: a read strobe always yields an acknowledge in the next cycle.
  assert_read_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.readNext |=> ackValid);

endmodule

// File: rtl/cfgTargetDecoder.sv
module cfgTargetDecoder
  import cfgPkg::*;
#(
  parameter int FUNC_BITS = 3,
  parameter logic [(1<<FUNC_BITS)-1:0] IMPL_MASK = 'h01,
  parameter logic [15:0] VENDOR_ID = 16'h1D2C,
  parameter logic [15:0] DEVICE_BASE = 16'h4410,
  parameter logic [23:0] CLASS_CODE = 24'h0C0330,
  parameter logic [6:0] LAYOUT_CODE = 7'h00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqSel,
  input  logic [1:0]           reqType,
  input  logic [FUNC_BITS-1:0] reqFunc,
  input  logic [1:0]           reqDword,
  input  logic [3:0]           reqByteEn,
  input  logic                 reqWrite,
  input  logic [31:0]          reqWdata,
  output logic                 ackValid,
  output logic [31:0]          rdData
);

  localparam int NUM_FUNC = 1 << FUNC_BITS;
  localparam logic [NUM_FUNC-1:0] EFF_MASK = IMPL_MASK | NUM_FUNC'(1);
  localparam logic IS_MULTI = |EFF_MASK[NUM_FUNC-1:1];

  cfgStrobe_t           strobe;
  logic [FUNC_BITS-1:0] funcIdx;
  logic                 multiFlag;

  cfgControl #(
    .FUNC_BITS (FUNC_BITS),
    .IMPL_MASK (IMPL_MASK)
  ) control (
    .reqValid  (reqValid),
    .reqSel    (reqSel),
    .reqType   (reqType),
    .reqFunc   (reqFunc),
    .reqDword  (reqDword),
    .reqWrite  (reqWrite),
    .strobe    (strobe),
    .funcIdx   (funcIdx),
    .multiFlag (multiFlag)
  );

  cfgDatapath #(
    .FUNC_BITS   (FUNC_BITS),
    .IMPL_MASK   (IMPL_MASK),
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_BASE (DEVICE_BASE),
    .CLASS_CODE  (CLASS_CODE),
    .LAYOUT_CODE (LAYOUT_CODE)
  ) datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .funcIdx   (funcIdx),
    .reqDword  (reqDword),
    .reqByteEn (reqByteEn),
    .reqWdata  (reqWdata),
    .multiFlag (multiFlag),
    .ackValid  (ackValid),
    .rdData    (rdData)
  );

  assert_no_claim_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !(reqSel && reqType == 2'b00) |=> !ackValid);

  assert_single_claim_R2: assert property (@(posedge clk) disable iff (!rstN)
    !IS_MULTI && reqValid && reqSel && reqType == 2'b00 |=> ackValid);

  assert_func0_claim_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSel && reqType == 2'b00 && reqFunc == '0 |=> ackValid);

  assert_absent_func_R3: assert property (@(posedge clk) disable iff (!rstN)
    IS_MULTI && reqValid && reqSel && reqType == 2'b00 && !EFF_MASK[reqFunc]
      |=> !ackValid);

  assert_idle_no_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !ackValid);

  assert_ones_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |-> rdData == 32'hFFFF_FFFF);

endmodule

// File: tb/cfgTargetDecoder_test.sv
module cfgTargetDecoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;
  localparam logic [7:0]  M_MASK = 8'hA5;   // functions 0, 2, 5, 7
  localparam logic [7:0]  S_MASK = 8'h01;
  localparam logic [6:0]  M_LAYOUT = 7'h7F;
  localparam logic [6:0]  S_LAYOUT = 7'h01;
  localparam logic [15:0] VENDOR = 16'h1D2C;
  localparam logic [15:0] DEV_BASE = 16'h4410;
  localparam logic [23:0] CLASS = 24'h0C0330;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqSel = 1'b0;
  logic [1:0]  reqType = 2'b00;
  logic [2:0]  reqFunc = 3'd0;
  logic [1:0]  reqDword = 2'd0;
  logic [3:0]  reqByteEn = 4'h0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = 32'h0;
  logic        ackM, ackS;
  logic [31:0] dataM, dataS;

  int total = 0;
  int bad = 0;
  logic [31:0] cmdM [8];
  logic [31:0] cmdS;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgTargetDecoder #(
    .FUNC_BITS(3), .IMPL_MASK(M_MASK), .VENDOR_ID(VENDOR),
    .DEVICE_BASE(DEV_BASE), .CLASS_CODE(CLASS), .LAYOUT_CODE(M_LAYOUT)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqType(reqType), .reqFunc(reqFunc), .reqDword(reqDword),
    .reqByteEn(reqByteEn), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .ackValid(ackM), .rdData(dataM)
  );

  cfgTargetDecoder #(
    .FUNC_BITS(3), .IMPL_MASK(S_MASK), .VENDOR_ID(VENDOR),
    .DEVICE_BASE(DEV_BASE), .CLASS_CODE(CLASS), .LAYOUT_CODE(S_LAYOUT)
  ) uutSingle (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqType(reqType), .reqFunc(reqFunc), .reqDword(reqDword),
    .reqByteEn(reqByteEn), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .ackValid(ackS), .rdData(dataS)
  );

  function automatic logic [31:0] identOf(input int f);
    return {DEV_BASE + 16'(f), VENDOR};
  endfunction

  function automatic logic [31:0] classOf(input int f);
    return {CLASS, 8'(f)};
  endfunction

  // Applies a command-register write: only bytes 0 and 1 are writable.
  function automatic logic [31:0] applyCmd(input logic [31:0] old,
                                           input logic [3:0] be,
                                           input logic [31:0] wd);
    logic [31:0] res;
    res = old;
    for (int b = 0; b < 2; b++) if (be[b]) res[8*b +: 8] = wd[8*b +: 8];
    return res;
  endfunction

  task automatic checkEq(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One request; returns acknowledge and data of both instances in the
  // acknowledge cycle, and checks that the following cycle is silent (R8, R9).
  task automatic issue(input logic sel, input logic [1:0] typ,
                       input logic [2:0] fn, input logic [1:0] dw,
                       input logic [3:0] be, input logic wr,
                       input logic [31:0] wd,
                       output logic aM, output logic [31:0] dM,
                       output logic aS, output logic [31:0] dS);
    @(negedge clk);
    reqValid = 1'b1; reqSel = sel; reqType = typ; reqFunc = fn;
    reqDword = dw; reqByteEn = be; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqSel = 1'b0; reqWrite = 1'b0;
    aM = ackM; dM = dataM; aS = ackS; dS = dataS;
    @(negedge clk);
    checkEq("R8", "ack after pulse (multi)", 32'(ackM), 32'd0);
    checkEq("R8", "ack after pulse (single)", 32'(ackS), 32'd0);
    checkEq("R9", "idle data (multi)", dataM, 32'hFFFF_FFFF);
  endtask

  task automatic testReset();
    checkEq("R8", "reset ack", 32'(ackM), 32'd0);
    checkEq("R9", "reset data", dataM, 32'hFFFF_FFFF);
    checkEq("R9", "reset data single", dataS, 32'hFFFF_FFFF);
  endtask

  task automatic testUnclaimed();
    logic aM, aS;
    logic [31:0] dM, dS;
    issue(1'b0, 2'b00, 3'd0, 2'd0, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
    checkEq("R1", "no select multi ack", 32'(aM), 32'd0);
    checkEq("R1", "no select single ack", 32'(aS), 32'd0);
    checkEq("R9", "no select data", dM, 32'hFFFF_FFFF);
    issue(1'b1, 2'b01, 3'd0, 2'd0, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
    checkEq("R1", "type 01 multi ack", 32'(aM), 32'd0);
    checkEq("R1", "type 01 single ack", 32'(aS), 32'd0);
  endtask

  task automatic testFunctionDecode();
    logic aM, aS;
    logic [31:0] dM, dS;
    for (int f = 0; f < 8; f++) begin
      issue(1'b1, 2'b00, 3'(f), 2'd0, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
      checkEq("R3", $sformatf("claim func %0d", f), 32'(aM), 32'(M_MASK[f]));
      checkEq("R6", $sformatf("ident func %0d", f), dM,
              M_MASK[f] ? identOf(f) : 32'hFFFF_FFFF);
      checkEq("R2", $sformatf("single claim func %0d", f), 32'(aS), 32'd1);
      checkEq("R2", $sformatf("single ident func %0d", f), dS, identOf(0));
    end
  endtask

  task automatic testHeader();
    logic aM, aS;
    logic [31:0] dM, dS;
    issue(1'b1, 2'b00, 3'd7, 2'd3, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
    checkEq("R5", "multi header", dM, 32'h00FF_0000);
    checkEq("R5", "single header", dS, 32'h0001_0000);
  endtask

  task automatic testOffsets();
    logic aM, aS;
    logic [31:0] dM, dS;
    for (int d = 0; d < 4; d++) begin
      issue(1'b1, 2'b00, 3'd5, 2'(d), 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
      checkEq("R4", $sformatf("claim dword %0d", d), 32'(aM), 32'd1);
      if (d == 2) checkEq("R6", "class func 5", dM, classOf(5));
      if (d == 1) checkEq("R7", "cmd reset func 5", dM, 32'h0);
    end
  endtask

  task automatic writeCmd(input logic [2:0] fn, input logic [3:0] be,
                          input logic [31:0] wd);
    logic aM, aS;
    logic [31:0] dM, dS;
    issue(1'b1, 2'b00, fn, 2'd1, be, 1'b1, wd, aM, dM, aS, dS);
    checkEq("R8", "write ack single", 32'(aS), 32'd1);
    checkEq("R9", "write ack data single", dS, 32'hFFFF_FFFF);
    if (M_MASK[fn]) begin
      checkEq("R8", "write ack multi", 32'(aM), 32'd1);
      checkEq("R9", "write ack data multi", dM, 32'hFFFF_FFFF);
      cmdM[fn] = applyCmd(cmdM[fn], be, wd);
    end else begin
      checkEq("R3", "write to absent function", 32'(aM), 32'd0);
    end
    cmdS = applyCmd(cmdS, be, wd);
  endtask

  task automatic testCommandWrites();
    logic aM, aS;
    logic [31:0] dM, dS;
    writeCmd(3'd2, 4'b1111, 32'hFFFF_FFFF);
    writeCmd(3'd5, 4'b0001, 32'h1234_56AB);
    writeCmd(3'd3, 4'b0010, 32'h0000_5A00);
    writeCmd(3'd7, 4'b1110, 32'hCAFE_C3C3);
    for (int f = 0; f < 8; f++) begin
      if (M_MASK[f]) begin
        issue(1'b1, 2'b00, 3'(f), 2'd1, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
        checkEq("R7", $sformatf("cmd readback func %0d", f), dM, cmdM[f]);
        checkEq("R7", "cmd readback single", dS, cmdS);
      end
    end
  endtask

  task automatic testReadOnlyWrites();
    logic aM, aS;
    logic [31:0] dM, dS;
    issue(1'b1, 2'b00, 3'd0, 2'd0, 4'hF, 1'b1, 32'h0, aM, dM, aS, dS);
    issue(1'b1, 2'b00, 3'd0, 2'd2, 4'hF, 1'b1, 32'h0, aM, dM, aS, dS);
    issue(1'b1, 2'b00, 3'd0, 2'd3, 4'hF, 1'b1, 32'h0, aM, dM, aS, dS);
    checkEq("R6", "read-only write acked", 32'(aM), 32'd1);
    issue(1'b1, 2'b00, 3'd0, 2'd0, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
    checkEq("R6", "ident after write", dM, identOf(0));
    issue(1'b1, 2'b00, 3'd0, 2'd2, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
    checkEq("R6", "class after write", dM, classOf(0));
    issue(1'b1, 2'b00, 3'd0, 2'd3, 4'h0, 1'b0, 32'h0, aM, dM, aS, dS);
    checkEq("R5", "header after write", dM, 32'h00FF_0000);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int f = 0; f < 8; f++) cmdM[f] = 32'h0;
    cmdS = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnclaimed();
    testFunctionDecode();
    testHeader();
    testOffsets();
    testCommandWrites();
    testReadOnlyWrites();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule